// File: doc/BRIEF.md
# Double-Buffered Synchronous Serial Transmitter

This block sends 8-bit or 9-bit words over a clocked serial link. The word goes out least significant bit first, with each bit launched on a rising edge of the shift clock. The host writes a word into a holding register. If the shift register is idle, the word moves on at once, which leaves the holding register free for the next word while the first one is still going out. The buffer-empty flag describes the holding register, not the wire. It only returns high when a waiting word has actually been handed to the shift register. This lets the host keep the link busy without gaps.

The block can act as clock master or as clock slave. As master, it divides the system clock to make the shift clock. It drives that clock only while there is work to do, and the clock rests low between transfers. As slave, the shift register is clocked directly by the externally supplied clock. Words already loaded therefore finish, and a held word is handed over, even when the system clock has stopped. The interrupt output repeats the empty flag when the interrupt is enabled.

Top module: `sstx_top`

## Requirements
- R1: After reset, `tx_empty` is 1, `ck_out` is 0 and `ser_out` is 0, and `irq` equals `irq_en`.
- R2: A write accepted while the shift register is idle is handed over within `HALF_PER`+1 system clocks in master mode. `tx_empty` is 0 in the clock after the write and returns to 1 before the word has finished.
- R3: A word written while another word is shifting waits in the holding register, and `tx_empty` stays 0. The word is loaded at the first rising shift-clock edge after the last bit period of the current word, and only then does `tx_empty` return to 1.
- R4: Bits leave on `ser_out` least significant bit first. Each bit changes on a rising shift-clock edge and holds across the following falling edge. With `nine_mode`=0 a frame is 8 bits long, and `wr_bit9` has no effect.
- R5: With `nine_mode`=1 at the time of the write, the frame is 9 bits long and its last bit is the `wr_bit9` value captured with the word.
- R6: A write strobe while `tx_en`=0 is ignored. `tx_empty` stays 1, no clock pulse appears and no bit is sent, even after `tx_en` is later set.
- R7: In master mode, `ck_out` has a period of 2×`HALF_PER` system clocks and gives exactly one rising edge per transmitted bit. It is low whenever no word is shifting and none is waiting.
- R8: In slave mode (`master_sel`=0), shifting is clocked only by `ext_ck`, and `ck_out` stays 0. A written word waits for the first `ext_ck` rising edge. Transfers and the handoff of a held word, including the rise of `tx_empty` and `irq`, complete with the system clock stopped.
- R9: `irq` is 1 exactly when `irq_en` is 1 and `tx_empty` is 1.
- R10: A write while a word is already waiting in the holding register replaces the waiting word. The replaced word is never sent.
- R11: Back-to-back words are sent with no idle shift-clock period between them. Two words produce 16 consecutive clock pulses in 8-bit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; host side and master clock divider |
| rst_n | input | 1 | Active-low reset: synchronous for the host side, asynchronous for the shift stage |
| wr_stb | input | 1 | Write strobe for the holding register |
| wr_data | input | WORD_W | Data word to send |
| wr_bit9 | input | 1 | Ninth bit, captured with the word |
| nine_mode | input | 1 | 1 selects 9-bit frames, captured with the word |
| tx_en | input | 1 | Transmit enable; gates writes and handoff |
| master_sel | input | 1 | 1 = clock master, 0 = clock slave |
| irq_en | input | 1 | Buffer-empty interrupt enable |
| ext_ck | input | 1 | External shift clock used in slave mode |
| ser_out | output | 1 | Serial data |
| ck_out | output | 1 | Shift clock driven in master mode, 0 otherwise |
| tx_empty | output | 1 | Holding register is free |
| irq | output | 1 | Buffer-empty interrupt |

## Verification
The bench builds the block with `WORD_W`=8 and `HALF_PER`=2, so one bit period takes four system clocks. This puts the early handoff of R2 and the delayed handoff of R3 only a couple of cycles apart, so both can be timed exactly in a short run. A 16-bit back-to-back burst and its pulse count then complete quickly. The slave cases use an `ext_ck` that is slower than the system clock and unrelated to it, and one case stops the system clock in the middle of a transfer so that a handoff happens with no system clock at all.

// File: rtl/sstx_pkg.sv
// Shared definitions for the synchronous serial transmitter.
// Assumes: frames are one data word, optionally followed by one extra bit.
package sstx_pkg;

    // Clock role of the link.
    typedef enum logic {
        ROLE_SLAVE  = 1'b0,
        ROLE_MASTER = 1'b1
    } role_e;

    // Number of bits in a frame for a given word width and ninth-bit choice.
    function automatic int unsigned frame_bits(input logic nine, input int unsigned w);
        return nine ? (w + 1) : w;
    endfunction

endpackage

// File: rtl/sstx_hold.sv
// Holding stage: captures host writes in the system clock domain.
// A toggle pair with the shift stage tracks whether a word is waiting.
// Assumes: the shift stage only reads the held word while a word is pending.
module sstx_hold #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              tx_en,
    input  logic              nine_mode,
    input  logic              wr_bit9,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_tgl,
    output logic [WORD_W:0]   held_word,
    output logic              held_nine,
    output logic              pending
);

    logic wr_tgl;

    // Word waiting whenever the write toggle is ahead of the read toggle.
    assign pending = wr_tgl ^ rd_tgl;

    // Capture an enabled write; advance the toggle only when the slot was free.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_word <= '0;
            held_nine <= 1'b0;
            wr_tgl    <= 1'b0;
        end else if (wr_stb && tx_en) begin
            held_word <= {nine_mode & wr_bit9, wr_data};
            held_nine <= nine_mode;
            if (!pending) begin
                wr_tgl <= ~wr_tgl;
            end
        end
    end

endmodule

// File: rtl/sstx_ckgen.sv
// Master shift-clock generator: divides the system clock by 2*HALF_PER.
// Starts a rising edge only when a word is shifting or waiting; always
// finishes a high phase, so the clock rests low.
// Assumes: HALF_PER >= 1.
module sstx_ckgen
    import sstx_pkg::*;
#(
    parameter int HALF_PER = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  role_e role,
    input  logic  want,
    output logic  sck_m
);

    localparam int DW = (HALF_PER > 1) ? $clog2(HALF_PER) : 1;
    localparam logic [DW-1:0] DLAST = DW'(HALF_PER - 1);

    logic [DW-1:0] div;

    // Count half periods and toggle the clock while there is work or a high phase to finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_m <= 1'b0;
            div   <= '0;
        end else if (role != ROLE_MASTER) begin
            sck_m <= 1'b0;
            div   <= '0;
        end else if (sck_m || want) begin
            if (div == DLAST) begin
                sck_m <= ~sck_m;
                div   <= '0;
            end else begin
                div <= div + 1'b1;
            end
        end else begin
            div <= '0;
        end
    end

endmodule

// File: rtl/sstx_shift.sv
// Shift stage: clocked only by the selected shift clock, so it keeps working
// with the system clock stopped. Loads a waiting word at a rising edge once
// the previous frame's last bit period is over, then shifts LSB first.
// Assumes: the reset is asynchronous here because this clock may be absent.
module sstx_shift
    import sstx_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic            sck,
    input  logic            rst_n,
    input  logic            load_ok,
    input  logic [WORD_W:0] held_word,
    input  logic            held_nine,
    output logic            rd_tgl,
    output logic            ser_out,
    output logic            busy
);

    localparam int RW = $clog2(WORD_W + 1);

    logic [WORD_W:0] frame;
    logic [RW-1:0]   rem;

    // Serial line is the low bit of the frame register.
    assign ser_out = frame[0];
    assign busy    = (rem != '0);

    // Shift out remaining bits, or take the waiting word when done.
    always_ff @(posedge sck or negedge rst_n) begin
        if (!rst_n) begin
            frame  <= '0;
            rem    <= '0;
            rd_tgl <= 1'b0;
        end else if (rem != '0) begin
            frame <= {1'b0, frame[WORD_W:1]};
            rem   <= rem - 1'b1;
        end else if (load_ok) begin
            frame  <= held_word;
            rem    <= RW'(frame_bits(held_nine, WORD_W) - 1);
            rd_tgl <= ~rd_tgl;
        end
    end

endmodule

// File: rtl/sstx_top.sv
// Double-buffered synchronous serial transmitter, top level.
// Host writes land in the holding stage; the shift stage runs on the master
// divider clock or on the external clock, depending on master_sel.
// Assumes: master_sel changes only while the link is idle; in slave mode
// writes are spaced from ext_ck rising edges by the host.
module sstx_top
    import sstx_pkg::*;
#(
    parameter int WORD_W   = 8,
    parameter int HALF_PER = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              wr_bit9,
    input  logic              nine_mode,
    input  logic              tx_en,
    input  logic              master_sel,
    input  logic              irq_en,
    input  logic              ext_ck,
    output logic              ser_out,
    output logic              ck_out,
    output logic              tx_empty,
    output logic              irq
);

    role_e           role;
    logic            pending;
    logic            rd_tgl;
    logic [WORD_W:0] held_word;
    logic            held_nine;
    logic            load_ok;
    logic            shf_busy;
    logic            sck_m;
    logic            sck;

    assign role     = role_e'(master_sel);
    assign load_ok  = pending & tx_en;
    assign sck      = (role == ROLE_MASTER) ? sck_m : ext_ck;
    assign ck_out   = sck_m;
    assign tx_empty = ~pending;
    assign irq      = irq_en & tx_empty;

    sstx_hold #(.WORD_W(WORD_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .tx_en     (tx_en),
        .nine_mode (nine_mode),
        .wr_bit9   (wr_bit9),
        .wr_data   (wr_data),
        .rd_tgl    (rd_tgl),
        .held_word (held_word),
        .held_nine (held_nine),
        .pending   (pending)
    );

    sstx_ckgen #(.HALF_PER(HALF_PER)) u_ckgen (
        .clk   (clk),
        .rst_n (rst_n),
        .role  (role),
        .want  (load_ok | shf_busy),
        .sck_m (sck_m)
    );

    sstx_shift #(.WORD_W(WORD_W)) u_shift (
        .sck       (sck),
        .rst_n     (rst_n),
        .load_ok   (load_ok),
        .held_word (held_word),
        .held_nine (held_nine),
        .rd_tgl    (rd_tgl),
        .ser_out   (ser_out),
        .busy      (shf_busy)
    );

endmodule

// File: rtl/sstx_chk.sv
// Property checker for sstx_top, attached with bind below.
// Assumes: checks are sampled on the system clock.
module sstx_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_stb,
    input logic tx_en,
    input logic master_sel,
    input logic tx_empty,
    input logic ck_out,
    input logic shf_busy
);

    // R2
    write_clears_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master_sel && wr_stb && tx_en) |=> !tx_empty);

    // R3
    handoff_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master_sel && $rose(tx_empty)) |-> $past(!shf_busy));

    // R6
    ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !tx_en && tx_empty) |=> tx_empty);

    // R7
    ck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master_sel && tx_empty && !shf_busy && !ck_out) |=> !ck_out);

    // R8
    slave_ck_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_sel) |=> !ck_out);

endmodule

bind sstx_top sstx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_stb     (wr_stb),
    .tx_en      (tx_en),
    .master_sel (master_sel),
    .tx_empty   (tx_empty),
    .ck_out     (ck_out),
    .shf_busy   (shf_busy)
);

// File: tb/sim_sstx_top.sv
module sim_sstx_top;
    localparam int WORD_W   = 8;
    localparam int HALF_PER = 2;
    localparam int BIT_CLKS = 2 * HALF_PER;

    typedef struct packed {
        logic [7:0] d;
        logic       b9;
        logic       nine;
        logic       mst;
    } vec_t;

    // data, ninth bit, 9-bit mode, master
    localparam vec_t VECS [6] = '{
        '{8'hA5, 1'b1, 1'b0, 1'b1},
        '{8'h3C, 1'b1, 1'b1, 1'b1},
        '{8'h81, 1'b0, 1'b1, 1'b1},
        '{8'h5A, 1'b0, 1'b0, 1'b0},
        '{8'hC3, 1'b1, 1'b1, 1'b0},
        '{8'h01, 1'b0, 1'b0, 1'b1}
    };

    logic clk = 1'b0;
    logic clk_run = 1'b1;
    logic rst_n = 1'b1;
    logic wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic wr_bit9 = 1'b0;
    logic nine_mode = 1'b0;
    logic tx_en = 1'b0;
    logic master_sel = 1'b1;
    logic irq_en = 1'b0;
    logic ext_ck = 1'b0;
    logic ser_out, ck_out, tx_empty, irq;

    int tests = 0;
    int fails = 0;
    logic rx_bits [0:63];
    int rxn = 0;
    int ck_rises = 0;

    always begin
        #2;
        if (clk_run) clk = ~clk;
    end

    sstx_top #(.WORD_W(WORD_W), .HALF_PER(HALF_PER)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
        .wr_bit9(wr_bit9), .nine_mode(nine_mode), .tx_en(tx_en),
        .master_sel(master_sel), .irq_en(irq_en), .ext_ck(ext_ck),
        .ser_out(ser_out), .ck_out(ck_out), .tx_empty(tx_empty), .irq(irq)
    );

    // Receiver model: samples the line on each falling edge of the active clock.
    wire rx_ck = master_sel ? ck_out : ext_ck;
    always @(negedge rx_ck) begin
        if (rxn < 64) rx_bits[rxn] = ser_out;
        rxn = rxn + 1;
    end
    always @(posedge ck_out) ck_rises = ck_rises + 1;

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int rx_word(input int start, input int n);
        int v;
        v = 0;
        for (int i = 0; i < n; i++) begin
            if (rx_bits[start + i] === 1'b1) v = v | (1 << i);
        end
        return v;
    endfunction

    task automatic write_word(input logic [7:0] d, input logic b9);
        @(negedge clk);
        wr_data = d;
        wr_bit9 = b9;
        wr_stb  = 1'b1;
        @(negedge clk);
        wr_stb  = 1'b0;
    endtask

    task automatic ext_pulse();
        ext_ck = 1'b1;
        #10;
        ext_ck = 1'b0;
        #10;
    endtask

    initial begin
        #600000;
        tests++;
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int nb;
        int expw;
        #1 rst_n = 1'b0;
        tx_en  = 1'b1;
        irq_en = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 tx_empty", int'(tx_empty), 1);
        chk("R1 ck_out", int'(ck_out), 0);
        chk("R1 ser_out", int'(ser_out), 0);
        chk("R1 irq", int'(irq), 1);
        // R9 interrupt gating
        irq_en = 1'b0;
        #1;
        chk("R9 irq disabled", int'(irq), 0);
        irq_en = 1'b1;

        // Table walk: R4 R5 R7 R8
        for (int i = 0; i < 6; i++) begin
            master_sel = VECS[i].mst;
            nine_mode  = VECS[i].nine;
            nb   = VECS[i].nine ? 9 : 8;
            expw = VECS[i].nine ? {23'd0, VECS[i].b9, VECS[i].d} : {24'd0, VECS[i].d};
            @(negedge clk);
            rxn = 0;
            ck_rises = 0;
            write_word(VECS[i].d, VECS[i].b9);
            if (VECS[i].mst) begin
                wait (rxn >= nb);
                repeat (3 * BIT_CLKS) @(negedge clk);
                chk("R7 bit count", rxn, nb);
                chk("R7 pulse count", ck_rises, nb);
                chk("R7 clock idles low", int'(ck_out), 0);
            end else begin
                repeat (3) @(negedge clk);
                chk("R8 waits for ext clock", int'(tx_empty), 0);
                for (int k = 0; k < nb; k++) ext_pulse();
                chk("R8 bit count", rxn, nb);
                chk("R8 no master pulses", ck_rises, 0);
            end
            chk(VECS[i].nine ? "R5 nine-bit word" : "R4 eight-bit word LSB first", rx_word(0, nb), expw);
            chk("R4 empty after frame", int'(tx_empty), 1);
        end

        // R6 writes ignored while disabled
        master_sel = 1'b1;
        nine_mode  = 1'b0;
        @(negedge clk);
        rxn = 0;
        ck_rises = 0;
        tx_en = 1'b0;
        write_word(8'hFF, 1'b0);
        repeat (10) @(negedge clk);
        chk("R6 empty kept", int'(tx_empty), 1);
        chk("R6 no pulses", ck_rises, 0);
        tx_en = 1'b1;
        repeat (4 * BIT_CLKS) @(negedge clk);
        chk("R6 nothing sent later", rxn, 0);

        // R2 R3 R11 double buffering
        write_word(8'h96, 1'b0);
        repeat (HALF_PER + 1) @(negedge clk);
        chk("R2 handed over early", int'(tx_empty), 1);
        chk("R2 still shifting", int'(rxn < 8), 1);
        write_word(8'h4D, 1'b0);
        chk("R3 held word clears empty", int'(tx_empty), 0);
        chk("R9 irq low while held", int'(irq), 0);
        wait (rxn >= 8);
        chk("R3 empty low at last bit", int'(tx_empty), 0);
        repeat (HALF_PER + 1) @(negedge clk);
        chk("R3 empty after handoff", int'(tx_empty), 1);
        chk("R9 irq follows empty", int'(irq), 1);
        wait (rxn >= 16);
        repeat (3 * BIT_CLKS) @(negedge clk);
        chk("R11 first word", rx_word(0, 8), 8'h96);
        chk("R11 second word", rx_word(8, 8), 8'h4D);
        chk("R11 gapless pulses", ck_rises, 16);

        // R10 overwrite of the waiting word
        rxn = 0;
        ck_rises = 0;
        write_word(8'h11, 1'b0);
        repeat (HALF_PER + 1) @(negedge clk);
        write_word(8'h22, 1'b0);
        write_word(8'hE7, 1'b0);
        wait (rxn >= 16);
        repeat (3 * BIT_CLKS) @(negedge clk);
        chk("R10 first word", rx_word(0, 8), 8'h11);
        chk("R10 replaced word", rx_word(8, 8), 8'hE7);
        chk("R10 no third word", rxn, 16);

        // R8 slave handoff with system clock stopped
        master_sel = 1'b0;
        @(negedge clk);
        rxn = 0;
        write_word(8'h6B, 1'b0);
        ext_ck = 1'b1;
        #10;
        write_word(8'hB4, 1'b0);
        chk("R8 second word held", int'(tx_empty), 0);
        @(negedge clk);
        clk_run = 1'b0;
        ext_ck = 1'b0;
        #10;
        for (int k = 0; k < 7; k++) ext_pulse();
        ext_ck = 1'b1;
        #10;
        chk("R8 empty without system clock", int'(tx_empty), 1);
        chk("R8 irq without system clock", int'(irq), 1);
        ext_ck = 1'b0;
        #10;
        for (int k = 0; k < 7; k++) ext_pulse();
        chk("R8 first word clockless", rx_word(0, 8), 8'h6B);
        chk("R8 second word clockless", rx_word(8, 8), 8'hB4);
        clk_run = 1'b1;
        repeat (4) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule